// File: doc/BRIEF.md
# Console Keyboard and Character Printer Controller

This block sits between a processor's I/O command path and an operator console made of a keyboard and a one-character-at-a-time printer. Software sends three kinds of command. A keyboard control byte sets the two console lamps, sets the key interrupt enables and can clear pending key interrupts. A printer control byte starts a character print or a carrier return, sets the printer interrupt enable and can clear the printer interrupt. A load-output command places the next character to print in the output register.

The keyboard reports each key press as a one-cycle event with a key kind and a character code. The block keeps the last typed data character, remembers which special key was pressed last, and latches three pending interrupt flags: request key, end-or-cancel, and return-or-data. A print or carrier-return operation keeps the printer busy for a fixed number of cycles and then latches a printer-pending flag. The interrupt line is the OR of each pending flag gated by its own enable. A flag set while its enable is off stays latched and raises the line once the enable is turned on. Software reads the state through a 16-bit sense word.

Top module: `console_kp_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first command or key, the sense word is 0x0000, both lamps are off, irq is 0, prt_busy is 0 and both strobes are 0.
- R2: A keyboard command (cmd_sel 0) sets lamp_request to bit 5 and lamp_proceed to bit 4 of cmd_data[7:0], on or off, from the next cycle.
- R3: A data key (key_kind 0) loads key_char into sense bits 15:8, sets the return-or-data pending bit (sense bit 3) and clears the pressed bits 5, 4 and 2. No other key kind changes bits 15:8.
- R4: A return key (kind 2) sets pressed bit 2 and pending bit 3. An end key (kind 3) sets pressed bit 4 and pending bit 6. A cancel key (kind 4) sets pressed bit 5 and pending bit 6. Each such key clears the other pressed bits. Key kinds 5 to 7 have no effect.
- R5: A request key (kind 1) sets sense bit 7 and leaves the character and the pressed bits unchanged.
- R6: A keyboard command with bit 0 set clears sense bits 7, 6 and 3 and keeps the character and the pressed bits. A key event in the same cycle is applied after the clear.
- R7: Keyboard bit 2 enables the request interrupt and bit 1 enables the end-or-cancel and return-or-data interrupts. irq is the OR of each pending flag with its enable. A latched flag raises irq as soon as its enable is set.
- R8: A load-output command (cmd_sel 2) copies cmd_data[15:8] to prt_char. cmd_sel 3 has no effect.
- R9: A printer command (cmd_sel 1) with bit 7 set while the printer is idle pulses prt_strobe for one cycle. prt_busy is 1 for PRT_CYCLES cycles, then falls as the printer-pending flag sets. Printer bit 2 is the enable for that flag's interrupt.
- R10: Printer bit 6 while the printer is idle pulses cr_strobe for one cycle and starts the same busy period.
- R11: Printer bits 7 and 6 are ignored while prt_busy is 1: no strobe is issued and the busy period is not extended.
- R12: Printer bit 0 clears the printer-pending flag. A completion in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_sel | input | 2 | 0 keyboard control, 1 printer control, 2 load output, 3 none |
| cmd_data | input | 16 | Control byte in [7:0], output character in [15:8] |
| key_valid | input | 1 | One-cycle key event strobe |
| key_kind | input | 3 | 0 data, 1 request, 2 return, 3 end, 4 cancel |
| key_char | input | 8 | Character code of a data key |
| lamp_request | output | 1 | Request-pending lamp |
| lamp_proceed | output | 1 | Proceed lamp |
| irq | output | 1 | Interrupt request |
| sense_word | output | 16 | Last character in [15:8], key status in [7:0] |
| prt_char | output | 8 | Character held for printing |
| prt_strobe | output | 1 | One-cycle print start pulse |
| cr_strobe | output | 1 | One-cycle carrier-return pulse |
| prt_busy | output | 1 | Printer operation in progress |

## Verification
The assertions assume that key_kind and cmd_sel are valid whenever their strobes are high, and that a key event and a command are each held for exactly one cycle. The bench drives every strobe on the falling edge and drops it after one rising edge, so it never holds an event across two edges. The same-cycle cases the assertions cover, a clear together with a key event and a clear together with a completion, are produced on purpose. The bench also sends key kind 7 and cmd_sel 3 to confirm that they change no state visible at the ports.

// File: rtl/console_kp_pkg.sv
package console_kp_pkg;
  typedef enum logic [2:0] {
    KEY_DATA   = 3'd0,
    KEY_REQ    = 3'd1,
    KEY_RETURN = 3'd2,
    KEY_END    = 3'd3,
    KEY_CANCEL = 3'd4
  } key_kind_e;

  typedef enum logic [1:0] {
    SEL_KBD  = 2'd0,
    SEL_PRT  = 2'd1,
    SEL_LOAD = 2'd2,
    SEL_NONE = 2'd3
  } cmd_sel_e;

  // keyboard control byte bits
  localparam int KC_LAMP_REQ  = 5;
  localparam int KC_LAMP_PROC = 4;
  localparam int KC_EN_REQ    = 2;
  localparam int KC_EN_OTHER  = 1;
  localparam int KC_CLEAR     = 0;

  // printer control byte bits
  localparam int PC_PRINT = 7;
  localparam int PC_CR    = 6;
  localparam int PC_EN    = 2;
  localparam int PC_CLEAR = 0;

  // status byte bits
  localparam int ST_REQ_PEND    = 7;
  localparam int ST_ENDCAN_PEND = 6;
  localparam int ST_CANCEL      = 5;
  localparam int ST_END         = 4;
  localparam int ST_RETDAT_PEND = 3;
  localparam int ST_RETURN      = 2;
endpackage

// File: rtl/console_rst_sync.sv
module console_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/console_kbd_unit.sv
module console_kbd_unit
  import console_kp_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_byte,
  input  logic              key_valid,
  input  logic [2:0]        key_kind,
  input  logic [CHAR_W-1:0] key_char,
  output logic              lamp_req,
  output logic              lamp_proc,
  output logic              irq_key,
  output logic [7:0]        status,
  output logic [CHAR_W-1:0] char_q
);
  logic              lamp_req_q, lamp_req_d, lamp_proc_q, lamp_proc_d;
  logic              en_req_q, en_req_d, en_oth_q, en_oth_d;
  logic              req_pend_q, req_pend_d;
  logic              ec_pend_q, ec_pend_d;
  logic              rd_pend_q, rd_pend_d;
  logic              p_can_q, p_can_d, p_end_q, p_end_d, p_ret_q, p_ret_d;
  logic [CHAR_W-1:0] char_d, char_r;
  logic              clr;

  assign clr = ctl_we && ctl_byte[KC_CLEAR];

  always_comb begin
    lamp_req_d  = lamp_req_q;
    lamp_proc_d = lamp_proc_q;
    en_req_d    = en_req_q;
    en_oth_d    = en_oth_q;
    req_pend_d  = req_pend_q;
    ec_pend_d   = ec_pend_q;
    rd_pend_d   = rd_pend_q;
    p_can_d     = p_can_q;
    p_end_d     = p_end_q;
    p_ret_d     = p_ret_q;
    char_d      = char_r;
    if (ctl_we) begin
      lamp_req_d  = ctl_byte[KC_LAMP_REQ];
      lamp_proc_d = ctl_byte[KC_LAMP_PROC];
      en_req_d    = ctl_byte[KC_EN_REQ];
      en_oth_d    = ctl_byte[KC_EN_OTHER];
    end
    if (clr) begin
      req_pend_d = 1'b0;
      ec_pend_d  = 1'b0;
      rd_pend_d  = 1'b0;
    end
    if (key_valid) begin
      case (key_kind)
        KEY_DATA: begin
          char_d    = key_char;
          rd_pend_d = 1'b1;
          p_can_d   = 1'b0;
          p_end_d   = 1'b0;
          p_ret_d   = 1'b0;
        end
        KEY_REQ: req_pend_d = 1'b1;
        KEY_RETURN: begin
          rd_pend_d = 1'b1;
          p_can_d   = 1'b0;
          p_end_d   = 1'b0;
          p_ret_d   = 1'b1;
        end
        KEY_END: begin
          ec_pend_d = 1'b1;
          p_can_d   = 1'b0;
          p_end_d   = 1'b1;
          p_ret_d   = 1'b0;
        end
        KEY_CANCEL: begin
          ec_pend_d = 1'b1;
          p_can_d   = 1'b1;
          p_end_d   = 1'b0;
          p_ret_d   = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lamp_req_q  <= 1'b0;
      lamp_proc_q <= 1'b0;
      en_req_q    <= 1'b0;
      en_oth_q    <= 1'b0;
      req_pend_q  <= 1'b0;
      ec_pend_q   <= 1'b0;
      rd_pend_q   <= 1'b0;
      p_can_q     <= 1'b0;
      p_end_q     <= 1'b0;
      p_ret_q     <= 1'b0;
      char_r      <= '0;
    end else begin
      lamp_req_q  <= lamp_req_d;
      lamp_proc_q <= lamp_proc_d;
      en_req_q    <= en_req_d;
      en_oth_q    <= en_oth_d;
      req_pend_q  <= req_pend_d;
      ec_pend_q   <= ec_pend_d;
      rd_pend_q   <= rd_pend_d;
      p_can_q     <= p_can_d;
      p_end_q     <= p_end_d;
      p_ret_q     <= p_ret_d;
      char_r      <= char_d;
    end
  end

  always_comb begin
    status                 = '0;
    status[ST_REQ_PEND]    = req_pend_q;
    status[ST_ENDCAN_PEND] = ec_pend_q;
    status[ST_CANCEL]      = p_can_q;
    status[ST_END]         = p_end_q;
    status[ST_RETDAT_PEND] = rd_pend_q;
    status[ST_RETURN]      = p_ret_q;
  end

  assign lamp_req  = lamp_req_q;
  assign lamp_proc = lamp_proc_q;
  assign char_q    = char_r;
  assign irq_key   = (req_pend_q && en_req_q) || ((ec_pend_q || rd_pend_q) && en_oth_q);

  // R5: a request key always latches its pending flag
  p_req_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_kind == KEY_REQ |=> status[ST_REQ_PEND]);

  // R6: a clear with no key event empties all key pending flags
  p_clear_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !key_valid |=> status[ST_REQ_PEND] == 1'b0 && status[ST_ENDCAN_PEND] == 1'b0
                          && status[ST_RETDAT_PEND] == 1'b0);

  // R3: the character only moves on a data key
  p_char_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_valid && key_kind == KEY_DATA) |=> $stable(char_q));

  // R4: at most one pressed bit is ever set
  p_pressed_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status[ST_CANCEL], status[ST_END], status[ST_RETURN]}));
endmodule

// File: rtl/console_prt_unit.sv
module console_prt_unit
  import console_kp_pkg::*;
#(
  parameter int CHAR_W     = 8,
  parameter int PRT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_byte,
  input  logic              load_we,
  input  logic [CHAR_W-1:0] load_char,
  output logic [CHAR_W-1:0] prt_char,
  output logic              prt_strobe,
  output logic              cr_strobe,
  output logic              busy,
  output logic              irq_prt
);
  localparam int CW = $clog2(PRT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(PRT_CYCLES);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CHAR_W-1:0] char_r, char_d;
  logic              pstb_q, pstb_d, cstb_q, cstb_d;
  logic              en_q, en_d, pend_q, pend_d;
  logic              start_print, start_cr, finish;

  assign busy        = (cnt_q != '0);
  assign finish      = (cnt_q == CW'(1));
  assign start_print = ctl_we && ctl_byte[PC_PRINT] && !busy;
  assign start_cr    = ctl_we && ctl_byte[PC_CR] && !busy;

  always_comb begin
    cnt_d  = cnt_q;
    char_d = char_r;
    en_d   = en_q;
    pend_d = pend_q;
    pstb_d = start_print;
    cstb_d = start_cr;
    if (load_we) char_d = load_char;
    if (ctl_we) begin
      en_d = ctl_byte[PC_EN];
      if (ctl_byte[PC_CLEAR]) pend_d = 1'b0;
    end
    if (busy) cnt_d = cnt_q - CW'(1);
    if (finish) pend_d = 1'b1;
    if (start_print || start_cr) cnt_d = LOAD_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      char_r <= '0;
      pstb_q <= 1'b0;
      cstb_q <= 1'b0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      char_r <= char_d;
      pstb_q <= pstb_d;
      cstb_q <= cstb_d;
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign prt_char   = char_r;
  assign prt_strobe = pstb_q;
  assign cr_strobe  = cstb_q;
  assign irq_prt    = pend_q && en_q;

  // R9: a print strobe is always accompanied by a busy printer
  p_strobe_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prt_strobe |-> busy);

  // R9: the last busy cycle ends in a pending printer flag
  p_done_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> pend_q && !busy);

  // R11: a start request while busy produces no strobe
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctl_we |=> !prt_strobe && !cr_strobe);

  // R12: a clear outside a completion drops the pending flag
  p_clear_pend_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_byte[PC_CLEAR] && !finish |=> !pend_q);
endmodule

// File: rtl/console_kp_ctrl.sv
module console_kp_ctrl
  import console_kp_pkg::*;
#(
  parameter int PRT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_sel,
  input  logic [15:0] cmd_data,
  input  logic        key_valid,
  input  logic [2:0]  key_kind,
  input  logic [7:0]  key_char,
  output logic        lamp_request,
  output logic        lamp_proceed,
  output logic        irq,
  output logic [15:0] sense_word,
  output logic [7:0]  prt_char,
  output logic        prt_strobe,
  output logic        cr_strobe,
  output logic        prt_busy
);
  localparam int CHAR_W = 8;

  logic              rst_i_n;
  logic              kbd_we, prt_we, load_we;
  logic              irq_key, irq_prt;
  logic [7:0]        kbd_status;
  logic [CHAR_W-1:0] kbd_char;

  console_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign kbd_we  = cmd_valid && (cmd_sel == SEL_KBD);
  assign prt_we  = cmd_valid && (cmd_sel == SEL_PRT);
  assign load_we = cmd_valid && (cmd_sel == SEL_LOAD);

  console_kbd_unit #(.CHAR_W(CHAR_W)) u_kbd (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ctl_we    (kbd_we),
    .ctl_byte  (cmd_data[7:0]),
    .key_valid (key_valid),
    .key_kind  (key_kind),
    .key_char  (key_char),
    .lamp_req  (lamp_request),
    .lamp_proc (lamp_proceed),
    .irq_key   (irq_key),
    .status    (kbd_status),
    .char_q    (kbd_char)
  );

  console_prt_unit #(.CHAR_W(CHAR_W), .PRT_CYCLES(PRT_CYCLES)) u_prt (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .ctl_we     (prt_we),
    .ctl_byte   (cmd_data[7:0]),
    .load_we    (load_we),
    .load_char  (cmd_data[15:8]),
    .prt_char   (prt_char),
    .prt_strobe (prt_strobe),
    .cr_strobe  (cr_strobe),
    .busy       (prt_busy),
    .irq_prt    (irq_prt)
  );

  assign sense_word = {kbd_char, kbd_status};
  assign irq        = irq_key || irq_prt;

  // R1: the status byte never shows the unused low bits
  p_status_unused_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    sense_word[1:0] == 2'b00);

  // R8: a load-output command lands the high byte on prt_char
  p_load_high_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    load_we |=> prt_char == $past(cmd_data[15:8]));
endmodule

// File: tb/tb_console_kp_ctrl.sv
module tb_console_kp_ctrl;
  localparam int NCYC = 5;

  logic        clk, rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_sel;
  logic [15:0] cmd_data;
  logic        key_valid;
  logic [2:0]  key_kind;
  logic [7:0]  key_char;
  logic        lamp_request, lamp_proceed, irq;
  logic [15:0] sense_word;
  logic [7:0]  prt_char;
  logic        prt_strobe, cr_strobe, prt_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  console_kp_ctrl #(.PRT_CYCLES(NCYC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .key_valid(key_valid), .key_kind(key_kind),
    .key_char(key_char), .lamp_request(lamp_request), .lamp_proceed(lamp_proceed),
    .irq(irq), .sense_word(sense_word), .prt_char(prt_char),
    .prt_strobe(prt_strobe), .cr_strobe(cr_strobe), .prt_busy(prt_busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: cv sel[2] data[16] kv kind[3] char[8] | sense[16] irq lamps{req,proc}
  localparam int NV = 13;
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 2'd0, 16'h0030, 1'b0, 3'd0, 8'h00, 16'h0000, 1'b0, 2'b11}, // R2 lamps on
    {1'b0, 2'd0, 16'h0000, 1'b1, 3'd0, 8'h41, 16'h4108, 1'b0, 2'b11}, // R3 data key
    {1'b1, 2'd0, 16'h0002, 1'b0, 3'd0, 8'h00, 16'h4108, 1'b1, 2'b00}, // R7 latched, enable late
    {1'b0, 2'd0, 16'h0000, 1'b1, 3'd2, 8'h00, 16'h410C, 1'b1, 2'b00}, // R4 return
    {1'b0, 2'd0, 16'h0000, 1'b1, 3'd3, 8'h00, 16'h4158, 1'b1, 2'b00}, // R4 end
    {1'b0, 2'd0, 16'h0000, 1'b1, 3'd1, 8'h55, 16'h41D8, 1'b1, 2'b00}, // R5 request
    {1'b1, 2'd0, 16'h0004, 1'b0, 3'd0, 8'h00, 16'h41D8, 1'b1, 2'b00}, // R7 request only
    {1'b1, 2'd0, 16'h0005, 1'b0, 3'd0, 8'h00, 16'h4110, 1'b0, 2'b00}, // R6 clear
    {1'b1, 2'd0, 16'h0003, 1'b1, 3'd4, 8'h00, 16'h4160, 1'b1, 2'b00}, // R6 clear + cancel
    {1'b0, 2'd0, 16'h0000, 1'b1, 3'd0, 8'h7A, 16'h7A48, 1'b1, 2'b00}, // R3 data again
    {1'b1, 2'd3, 16'hFF01, 1'b0, 3'd0, 8'h00, 16'h7A48, 1'b1, 2'b00}, // R8 sel 3 ignored
    {1'b0, 2'd0, 16'h0000, 1'b1, 3'd7, 8'h33, 16'h7A48, 1'b1, 2'b00}, // R4 kind 7 ignored
    {1'b1, 2'd0, 16'h0001, 1'b0, 3'd0, 8'h00, 16'h7A00, 1'b0, 2'b00}  // R6 clear all
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cmd_valid = 1'b0; cmd_sel = 2'd3; cmd_data = '0;
    key_valid = 1'b0; key_kind = '0; key_char = '0;
  endtask

  // drive one cycle of a command, then sample after the edge
  task automatic send_cmd(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_data = data;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    wait_cycles(3);
    chk("R1 sense", 32'(sense_word), 32'h0);
    chk("R1 irq/busy/lamps", {28'h0, irq, prt_busy, lamp_request, lamp_proceed}, 32'h0);
    rst_n = 1'b1;
    wait_cycles(4);
    chk("R1 after release", {15'h0, sense_word, irq, prt_busy, prt_strobe, cr_strobe},
        32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmd_valid = VEC[i][49];
      cmd_sel   = VEC[i][48:47];
      cmd_data  = VEC[i][46:31];
      key_valid = VEC[i][30];
      key_kind  = VEC[i][29:27];
      key_char  = VEC[i][26:19];
      @(negedge clk);
      idle_inputs();
      chk($sformatf("R2-vector %0d sense", i), 32'(sense_word), 32'(VEC[i][18:3]));
      chk($sformatf("R7 vector %0d irq", i), 32'(irq), 32'(VEC[i][2]));
      chk($sformatf("R2 vector %0d lamps", i), {30'h0, lamp_request, lamp_proceed},
          32'(VEC[i][1:0]));
    end

    // R8: load output takes the high byte
    send_cmd(2'd2, 16'hC1FF);
    chk("R8 prt_char", 32'(prt_char), 32'hC1);

    // R9: print with enable
    send_cmd(2'd1, 16'h0084);
    chk("R9 strobe", {30'h0, prt_strobe, cr_strobe}, 32'h2);
    chk("R9 busy start", 32'(prt_busy), 32'h1);
    wait_cycles(1);
    chk("R9 strobe one cycle", 32'(prt_strobe), 32'h0);
    wait_cycles(NCYC - 2);
    chk("R9 still busy", {30'h0, prt_busy, irq}, 32'h2);
    wait_cycles(1);
    chk("R9 done irq", {30'h0, prt_busy, irq}, 32'h1);

    // R12: clear keeping enable
    send_cmd(2'd1, 16'h0005);
    chk("R12 clear", 32'(irq), 32'h0);

    // R7/R9: pending latched with enable off, raised later
    send_cmd(2'd1, 16'h0080);
    wait_cycles(NCYC);
    chk("R9 pend no enable", {30'h0, prt_busy, irq}, 32'h0);
    send_cmd(2'd1, 16'h0004);
    chk("R7 printer enable late", 32'(irq), 32'h1);
    send_cmd(2'd1, 16'h0001);
    chk("R12 clear disable", 32'(irq), 32'h0);

    // R10 and R11: carrier return, start while busy is ignored
    send_cmd(2'd1, 16'h0040);
    chk("R10 cr strobe", {30'h0, prt_strobe, cr_strobe}, 32'h1);
    chk("R10 busy", 32'(prt_busy), 32'h1);
    send_cmd(2'd1, 16'h00C4);
    chk("R11 no strobe", {30'h0, prt_strobe, cr_strobe}, 32'h0);
    wait_cycles(NCYC - 3);
    chk("R11 still busy", 32'(prt_busy), 32'h1);
    wait_cycles(1);
    chk("R11 not extended", {30'h0, prt_busy, irq}, 32'h1);

    // R12: clear in the completion cycle loses
    send_cmd(2'd1, 16'h0085);
    wait_cycles(NCYC - 2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = 2'd1; cmd_data = 16'h0005;
    @(negedge clk);
    idle_inputs();
    chk("R12 completion wins", {30'h0, prt_busy, irq}, 32'h1);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", {14'h0, sense_word, irq, prt_busy}, 32'h0);
    wait_cycles(2);
    rst_n = 1'b1;
    wait_cycles(3);
    chk("R1 prt_char reset", 32'(prt_char), 32'h0);

    finish_run();
  end
endmodule